// File: doc/BRIEF.md
# Jump-Controlled Shift Register Stage

This block is a single stage of a cascaded sequence generator. It keeps an 18-cell shift register, `state`, in which every cell is either a plain shift cell or a jump cell. A cell is a jump cell when it adds its own previous value to the value it takes from its left neighbour. Each cell belongs to one of two families, F or S. The incoming jump-control bit selects which family jumps and which family shifts. The register advances on every clock edge unless a seed is being loaded.

A key-map function condenses nine register bits and a 16-bit key word into one outgoing jump-control bit. That bit feeds the next stage of a chain. The first stage of a chain has its jump-control input tied to 0. Chains alternate between two stage flavours, odd and even, and the parameter `STAGE_ODD` selects which flavour an instance is. The flavour fixes the cell family pattern and the feedback taps.

Top module: `jcsg_stage`

## Requirements
- R1: While `rst_n` is low, `state` holds `RESET_STATE`, which defaults to 18'h00001.
- R2: When `seed_load` is high at a clock edge, `state` takes `seed` on that edge, whatever `jc_in` is.
- R3: Cell k is held in bit k-1 of `state`. A cell in shift mode, other than bit 0, takes the previous value of the bit below it.
- R4: A cell in jump mode takes the XOR of its left input and its own previous value.
- R5: An F cell is in jump mode when `jc_in` is 1, and an S cell is in jump mode when `jc_in` is 0. In an odd stage, reading from cell 18 down to cell 1, the families are S S F S S S F S F F F F F F S F S S.
- R6: The left input of bit 0 is the XOR of the previous values of the tap bits. In an odd stage the taps are bits 17, 10 and 0.
- R7: An even stage (`STAGE_ODD`=0) swaps the family of every cell and uses taps at bits 17, 7 and 0.
- R8: The key map works combinationally from the current `state` and `key`, and produces `jc_out` in six steps:
  - The selected bits v0..v8 are `state` bits 1, 2, 4, 6, 9, 11, 13, 15 and 17, in that order.
  - For each key nibble j from 0 to 3, bit b of the lookup index is v[(4j+b) mod 9], and the index is XORed with `key[4j+3:4j]`.
  - The index is looked up in the table that maps 0..15 to 12, 5, 6, 11, 9, 0, 10, 13, 3, 14, 15, 8, 4, 7, 1, 2.
  - The four lookup results are XORed together into a 4-bit value a.
  - The key bit is a0 ^ (a1 & a2) ^ a3.
  - `jc_out` is the parity of v0..v8 XOR the key bit.
- R9: An all-zero `state` stays all-zero while no seed is loaded, for any `jc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register steps on every rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Load `seed` into the register on this edge |
| seed | input | 18 | Value to load |
| jc_in | input | 1 | Jump control from the previous stage |
| key | input | 16 | Key word for the key map |
| jc_out | output | 1 | Jump control for the next stage |
| state | output | 18 | Current register contents |

## Verification
A wrong cell mode or a wrong feedback tap corrupts one bit of `state` on the very next edge. That error then moves up the register by one bit per cycle. It reaches `jc_out` as soon as it lands on a selected bit, which is at most two cycles later. The bench steps a behavioural model alongside both an odd and an even instance. It holds `jc_in` steady at each level, alternates it, and randomises it. It compares `state` after every edge and `jc_out` before every edge, so a fault is reported in the cycle it first appears. Seeds of all zeros and all ones cover the fixed point and the case where every jump cell cancels.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;
  // 4-bit substitution table, entry x held at bits [4x+3:4x]
  localparam logic [63:0] SBOX_TBL     = 64'h2174_8FE3_DA09_B65C;
  // family pattern of an odd stage, bit k-1 = cell k, 1 = F cell
  localparam logic [17:0] PAT_ODD      = 18'h08BF4;
  localparam logic [17:0] TAPS_ODD     = 18'h20401;
  localparam logic [17:0] TAPS_EVEN    = 18'h20081;
  // nine register bits that feed the key map
  localparam logic [17:0] SEL_MASK_DEF = 18'h2AA56;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    return SBOX_TBL[{x, 2'b00} +: 4];
  endfunction

  // a cell jumps when its family matches the incoming control level
  function automatic logic cell_jumps(input logic is_f, input logic jc);
    return is_f ~^ jc;
  endfunction

  function automatic logic key_bit(input logic [3:0] a);
    return a[0] ^ (a[1] & a[2]) ^ a[3];
  endfunction
endpackage

// File: rtl/csg_cell_mode.sv
`timescale 1ns/1ps
module csg_cell_mode import csg_pkg::*; #(
  parameter int unsigned N = 18,
  parameter logic [N-1:0] PATTERN = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         jc_in,
  output logic [N-1:0] jump_en
);
  for (genvar i = 0; i < N; i++) begin : g_mode
    assign jump_en[i] = cell_jumps(PATTERN[i], jc_in);
  end

  // R5: every cell changes family role when the control toggles
  assert_mode_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(jc_in) |-> (jump_en == ~$past(jump_en)));
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(jc_in) |-> $stable(jump_en));
endmodule

// File: rtl/csg_shift_reg.sv
`timescale 1ns/1ps
module csg_shift_reg #(
  parameter int unsigned N = 18,
  parameter logic [N-1:0] TAPS = '0,
  parameter logic [N-1:0] RESET_STATE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] seed,
  input  logic [N-1:0] jump_en,
  output logic [N-1:0] q
);
  logic         fb_bit;
  logic [N-1:0] d;

  assign fb_bit = ^(q & TAPS);

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic from_left;
    if (i == 0) begin : g_head
      assign from_left = fb_bit;
    end else begin : g_body
      assign from_left = q[i-1];
    end
    assign d[i] = from_left ^ (jump_en[i] & q[i]);

    if (i > 0) begin : g_chk
      assert_shift_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !jump_en[i]) |=> (q[i] == $past(q[i-1])));
      assert_jump_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && jump_en[i]) |=> (q[i] == ($past(q[i-1]) ^ $past(q[i]))));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_STATE;
    else if (load) q <= seed;
    else           q <= d;
  end

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(seed)));
  assert_feedback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !jump_en[0]) |=> (q[0] == $past(^(q & TAPS))));
  assert_zero_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (q == '0)) |=> (q == '0));
endmodule

// File: rtl/csg_key_map.sv
`timescale 1ns/1ps
module csg_key_map import csg_pkg::*; #(
  parameter int unsigned N = 18,
  parameter int unsigned KEY_W = 16,
  parameter int unsigned SEL_N = 9,
  parameter logic [N-1:0] SEL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     state,
  input  logic [KEY_W-1:0] key,
  output logic             jc_out
);
  localparam int unsigned NIBS = KEY_W / 4;

  // first selected bit (lowest index) ends up in sel_bits[0]
  function automatic logic [SEL_N-1:0] gather(input logic [N-1:0] s);
    logic [SEL_N-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++)
      if (SEL_MASK[i]) v = {s[i], v[SEL_N-1:1]};
    return v;
  endfunction

  logic [SEL_N-1:0] sel_bits;
  logic [3:0]       idx [NIBS];
  logic [3:0]       mix [NIBS];
  logic [3:0]       sbox_acc;

  assign sel_bits = gather(state);

  for (genvar j = 0; j < NIBS; j++) begin : g_nib
    for (genvar b = 0; b < 4; b++) begin : g_bit
      assign idx[j][b] = sel_bits[(4*j+b) % SEL_N];
    end
    assign mix[j] = sbox4(idx[j] ^ key[4*j +: 4]);
  end

  always_comb begin
    sbox_acc = '0;
    for (int j = 0; j < NIBS; j++) sbox_acc ^= mix[j];
  end

  assign jc_out = (^sel_bits) ^ key_bit(sbox_acc);

  // R8: output is a pure function of state and key
  assert_keymap_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(state) && $stable(key)) |-> $stable(jc_out));
endmodule

// File: rtl/jcsg_stage.sv
`timescale 1ns/1ps
module jcsg_stage import csg_pkg::*; #(
  parameter int unsigned N = 18,
  parameter int unsigned KEY_W = 16,
  parameter int unsigned SEL_N = 9,
  parameter bit STAGE_ODD = 1'b1,
  parameter logic [N-1:0] RESET_STATE = N'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [N-1:0]     seed,
  input  logic             jc_in,
  input  logic [KEY_W-1:0] key,
  output logic             jc_out,
  output logic [N-1:0]     state
);
  localparam logic [N-1:0] PATTERN  = STAGE_ODD ? N'(PAT_ODD) : ~N'(PAT_ODD);
  localparam logic [N-1:0] TAPS     = STAGE_ODD ? N'(TAPS_ODD) : N'(TAPS_EVEN);
  localparam logic [N-1:0] SEL_MASK = N'(SEL_MASK_DEF);

  logic [N-1:0] jump_en;

  csg_cell_mode #(.N(N), .PATTERN(PATTERN)) u_mode (
    .clk(clk), .rst_n(rst_n), .jc_in(jc_in), .jump_en(jump_en)
  );

  csg_shift_reg #(.N(N), .TAPS(TAPS), .RESET_STATE(RESET_STATE)) u_reg (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed),
    .jump_en(jump_en), .q(state)
  );

  csg_key_map #(.N(N), .KEY_W(KEY_W), .SEL_N(SEL_N), .SEL_MASK(SEL_MASK)) u_kmap (
    .clk(clk), .rst_n(rst_n), .state(state), .key(key), .jc_out(jc_out)
  );
endmodule

// File: tb/sim_jcsg_stage.sv
`timescale 1ns/1ps
module sim_jcsg_stage;
  logic        clk = 1'b0, rst_n = 1'b0, seed_load = 1'b0, jc_in = 1'b0;
  logic [17:0] seed = '0;
  logic [15:0] key = '0;
  logic        jco_odd, jco_even;
  logic [17:0] st_odd, st_even;
  int vectors = 0, fails = 0;
  logic [17:0] exp_odd, exp_even;

  always #4 clk = ~clk;

  jcsg_stage #(.STAGE_ODD(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .seed_load(seed_load),
    .seed(seed), .jc_in(jc_in), .key(key), .jc_out(jco_odd), .state(st_odd));
  jcsg_stage #(.STAGE_ODD(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .seed_load(seed_load),
    .seed(seed), .jc_in(jc_in), .key(key), .jc_out(jco_even), .state(st_even));

  // behavioural reference
  string PAT = "SSFSSSFSFFFFFFSFSS";   // cell 18 first
  int taps_odd[$]  = '{17, 10, 0};
  int taps_even[$] = '{17, 7, 0};
  int selq[$] = '{1, 2, 4, 6, 9, 11, 13, 15, 17};
  int sbox[16] = '{12, 5, 6, 11, 9, 0, 10, 13, 3, 14, 15, 8, 4, 7, 1, 2};

  function automatic bit fam_f(int i, bit odd);
    bit f = (PAT.getc(17 - i) == "F");
    return odd ? f : !f;
  endfunction

  function automatic logic [17:0] model_step(bit odd, logic [17:0] s, bit jc);
    logic [17:0] n;
    bit fb = 0;
    if (odd) foreach (taps_odd[t]) fb ^= s[taps_odd[t]];
    else     foreach (taps_even[t]) fb ^= s[taps_even[t]];
    for (int i = 0; i < 18; i++) begin
      bit left = (i == 0) ? fb : s[i-1];
      n[i] = (fam_f(i, odd) == jc) ? (left ^ s[i]) : left;
    end
    return n;
  endfunction

  function automatic bit model_jc(logic [17:0] s, logic [15:0] k);
    int v[9];
    int par = 0, acc = 0;
    for (int m = 0; m < 9; m++) begin v[m] = s[selq[m]]; par ^= v[m]; end
    for (int j = 0; j < 4; j++) begin
      int ix = 0;
      for (int b = 0; b < 4; b++) ix |= v[(4*j + b) % 9] << b;
      ix ^= (k >> (4*j)) & 15;
      acc ^= sbox[ix];
    end
    return bit'(par ^ (acc & 1) ^ (((acc >> 1) & (acc >> 2)) & 1) ^ ((acc >> 3) & 1));
  endfunction

  task automatic chk_state(bit odd, logic [17:0] act, logic [17:0] exp, bit jc, bit ld, string req0);
    vectors++;
    if (act !== exp) begin
      string req;
      int fb = -1;
      for (int i = 17; i >= 0; i--) if (act[i] !== exp[i]) fb = i;
      if (req0 != "")      req = req0;
      else if (ld)         req = "R2";
      else if (exp == '0)  req = "R9";
      else if (fb == 0)    req = "R6";
      else if (fam_f(fb, odd) == jc) req = "R5 R4";
      else                 req = "R5 R3";
      if (!odd) req = {"R7 ", req};
      fails++;
      $display("FAIL %s stage=%s state got %h expected %h", req, odd ? "odd" : "even", act, exp);
    end
  endtask

  task automatic chk_jc(bit odd, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R8 stage=%s jc_out got %b expected %b", odd ? "odd" : "even", act, exp);
    end
  endtask

  // one clock: drive at negedge, check key map before edge, state after
  task automatic step(bit ld, logic [17:0] sd, bit jc, logic [15:0] k);
    logic [17:0] n_odd, n_even;
    seed_load = ld; seed = sd; jc_in = jc; key = k;
    #1;
    chk_jc(1'b1, jco_odd, model_jc(exp_odd, k));
    chk_jc(1'b0, jco_even, model_jc(exp_even, k));
    n_odd  = ld ? sd : model_step(1'b1, exp_odd, jc);
    n_even = ld ? sd : model_step(1'b0, exp_even, jc);
    @(posedge clk); @(negedge clk);
    chk_state(1'b1, st_odd, n_odd, jc, ld, "");
    chk_state(1'b0, st_even, n_even, jc, ld, "");
    exp_odd = n_odd; exp_even = n_even;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset value held while reset is low
    chk_state(1'b1, st_odd, 18'h00001, 1'b0, 1'b0, "R1");
    chk_state(1'b0, st_even, 18'h00001, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    exp_odd = 18'h00001; exp_even = 18'h00001;
    // R3 R4 R5 R6: control held low, then held high
    for (int c = 0; c < 40; c++) step(1'b0, '0, 1'b0, 16'h0000);
    for (int c = 0; c < 40; c++) step(1'b0, '0, 1'b1, 16'hA5C3);
    // R2: seed load, then alternating control
    step(1'b1, 18'h2B3C7, 1'b1, 16'h1234);
    for (int c = 0; c < 40; c++) step(1'b0, '0, c[0], 16'(c * 16'h0F1D));
    // all ones: every jump cell cancels against its neighbour
    step(1'b1, 18'h3FFFF, 1'b0, 16'hFFFF);
    for (int c = 0; c < 20; c++) step(1'b0, '0, 1'b1, 16'hFFFF);
    // R9: all-zero fixed point under random control
    step(1'b1, 18'h00000, 1'b0, 16'h8001);
    for (int c = 0; c < 20; c++) step(1'b0, '0, 1'($urandom_range(0, 1)), 16'($urandom));
    // random mix with occasional loads, R8 under random keys
    for (int c = 0; c < 300; c++) begin
      bit ld = ($urandom_range(0, 15) == 0);
      step(ld, 18'($urandom), 1'($urandom_range(0, 1)), 16'($urandom));
    end
    // R2: load wins over control on the same edge
    step(1'b1, 18'h15A5A, 1'b1, 16'h0F0F);
    step(1'b1, 18'h0C3C3, 1'b0, 16'hF0F0);
    finish_run();
  end
endmodule